// File: doc/BRIEF.md
# Serial ADC Interface Sequencer

This block is the digital control side of a converter peripheral with a three-wire serial port: an active-low chip select, a serial clock supplied from outside, and a serial data line. It runs a fixed cycle of three phases: convert, sleep and data output. A conversion timer stands in for the analog modulator. When the timer expires, the value on a parallel sample input is captured into a static result register. The block then sleeps until the host pulls chip select and the serial clock low together. It then shifts the stored result out, most significant bit first. The host samples each bit on a rising serial clock edge.

A reset input starts an internal power-on reset interval that clears every register. A conversion begins when that interval ends. Chip select and the serial clock are brought into the system clock domain through two-flop synchronisers. A change on either pin therefore acts on the sequencer at the third rising system clock edge after it. The output enable follows chip select directly. A low-power flag tells the host that the block is asleep and deselected.

Top module: `adc_serial_seq`

## Requirements
- R1: The phases always follow the order convert, sleep, data output, then convert again. Sleep is entered only from convert, and data output only from sleep.
- R2: While `rst` is high, all registers are cleared and `low_power`, `sdo` and `sdo_oe` (with `cs_n` high) are 0. After `rst` falls, the power-on interval lasts POR_CYCLES clock cycles, and then a conversion starts.
- R3: A conversion lasts exactly CONV_CYCLES clock cycles. Activity on `cs_n` or `sck` during a conversion neither ends it nor restarts it.
- R4: At the end of a conversion, `sample_in` is captured into the result register.
- R5: Sleep is left for data output only when the synchronised `cs_n` and `sck` are both low at the same time. Either one low on its own keeps the block asleep.
- R6: On entering data output, `sdo` presents bit 15 (the MSB) of the stored result.
- R7: Each falling `sck` edge during data output moves `sdo` to the next lower bit of the result.
- R8: The 16th falling `sck` edge ends data output and starts a new conversion. The conversion starts 3 clock cycles after the edge.
- R9: A rising edge of `cs_n` during data output ends it at once, whatever the bit position, and starts a new conversion 3 clock cycles after the edge.
- R10: While asleep, the result register keeps its value no matter how long the block sleeps or how `sample_in` changes.
- R11: `low_power` is 1 exactly when the block is asleep and the synchronised `cs_n` is high. It goes to 0 when `cs_n` is low, including while `sck` stays high.
- R12: `sdo_oe` equals the inverse of `cs_n`. `sdo` is 0 whenever `sdo_oe` is 0 or the block is not in data output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Active-high reset; starts the power-on interval |
| cs_n | input | 1 | Active-low chip select from the host |
| sck | input | 1 | Serial clock from the host |
| sample_in | input | DATA_W | Parallel conversion value, captured when a conversion ends |
| sdo | output | 1 | Serial data, MSB first |
| sdo_oe | output | 1 | Output enable for the data pin, high while selected |
| low_power | output | 1 | High while asleep and deselected |

## Verification
A wrong phase shows up at the ports within a few clock cycles. The `low_power` flag rises at the wrong cycle, or fails to rise once chip select is high after a conversion. The bench counts cycles from each triggering pin change to that rise and expects an exact value. A corrupted bit index or result register shows up at the next sampled bit on `sdo`, so every bit of every readout is compared against the value driven on `sample_in`. An early exit from a conversion or from sleep shifts the measured conversion length or changes the data that is read back.

// File: rtl/adc_serial_seq.sv
module adc_serial_seq #(
  parameter int DATA_W      = 16,
  parameter int CONV_CYCLES = 1665000,
  parameter int POR_CYCLES  = 25000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cs_n,
  input  logic              sck,
  input  logic [DATA_W-1:0] sample_in,
  output logic              sdo,
  output logic              sdo_oe,
  output logic              low_power
);
  localparam int IDX_W   = (DATA_W > 1) ? $clog2(DATA_W) : 1;
  localparam int CNT_MAX = (CONV_CYCLES > POR_CYCLES) ? CONV_CYCLES : POR_CYCLES;
  localparam int CNT_W   = $clog2(CNT_MAX + 1);
  localparam logic [1:0] ST_POR = 2'd0, ST_CONV = 2'd1, ST_SLEEP = 2'd2, ST_DOUT = 2'd3;

  logic [1:0]        state;
  logic [CNT_W-1:0]  cnt;
  logic [IDX_W-1:0]  idx;
  logic [DATA_W-1:0] result;
  logic [2:0]        cs_p, sck_p;

  logic cs_s, sck_s, cs_rise, sck_fall;
  assign cs_s     = cs_p[1];
  assign sck_s    = sck_p[1];
  assign cs_rise  = cs_p[1] & ~cs_p[2];
  assign sck_fall = ~sck_p[1] & sck_p[2];

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= ST_POR;
      cnt    <= '0;
      idx    <= '0;
      result <= '0;
      cs_p   <= '1;
      sck_p  <= '1;
    end else begin
      cs_p  <= {cs_p[1:0], cs_n};
      sck_p <= {sck_p[1:0], sck};
      case (state)
        ST_POR: begin
          if (cnt == CNT_W'(POR_CYCLES - 1)) begin
            state <= ST_CONV;
            cnt   <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_CONV: begin
          if (cnt == CNT_W'(CONV_CYCLES - 1)) begin
            state  <= ST_SLEEP;
            cnt    <= '0;
            result <= sample_in;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_SLEEP: begin
          if (!cs_s && !sck_s) begin
            state <= ST_DOUT;
            idx   <= IDX_W'(DATA_W - 1);
          end
        end
        default: begin
          if (cs_rise) begin
            state <= ST_CONV;
            cnt   <= '0;
          end else if (sck_fall) begin
            if (idx == '0) begin
              state <= ST_CONV;
              cnt   <= '0;
            end else begin
              idx <= idx - 1'b1;
            end
          end
        end
      endcase
    end
  end

  assign sdo_oe    = ~cs_n;
  assign sdo       = sdo_oe & (state == ST_DOUT) & result[idx];
  assign low_power = (state == ST_SLEEP) & cs_s;
endmodule

// File: rtl/adc_serial_seq_chk.sv
module adc_serial_seq_chk #(
  parameter int DATA_W      = 16,
  parameter int CONV_CYCLES = 1665000,
  parameter int POR_CYCLES  = 25000
) (
  input logic                        clk,
  input logic                        rst,
  input logic [1:0]                  state,
  input logic [$clog2(((CONV_CYCLES > POR_CYCLES) ? CONV_CYCLES : POR_CYCLES) + 1)-1:0] cnt,
  input logic [((DATA_W > 1) ? $clog2(DATA_W) : 1)-1:0] idx,
  input logic [DATA_W-1:0]           result,
  input logic [DATA_W-1:0]           sample_in,
  input logic                        cs_s,
  input logic                        sck_s,
  input logic                        cs_rise,
  input logic                        sck_fall,
  input logic                        sdo,
  input logic                        sdo_oe,
  input logic                        low_power
);
  localparam int IDX_W   = (DATA_W > 1) ? $clog2(DATA_W) : 1;
  localparam int CNT_MAX = (CONV_CYCLES > POR_CYCLES) ? CONV_CYCLES : POR_CYCLES;
  localparam int CNT_W   = $clog2(CNT_MAX + 1);
  localparam logic [1:0] ST_POR = 2'd0, ST_CONV = 2'd1, ST_SLEEP = 2'd2, ST_DOUT = 2'd3;

  assert_sleep_from_conv_R1: assert property (@(posedge clk) disable iff (rst)
    (state == ST_SLEEP && $past(state) != ST_SLEEP) |-> $past(state) == ST_CONV);
  assert_dout_from_sleep_R1: assert property (@(posedge clk) disable iff (rst)
    (state == ST_DOUT && $past(state) != ST_DOUT) |-> $past(state) == ST_SLEEP);
  assert_por_to_conv_R2: assert property (@(posedge clk) disable iff (rst)
    ($past(state) == ST_POR && state != ST_POR) |-> state == ST_CONV);
  assert_conv_full_R3: assert property (@(posedge clk) disable iff (rst)
    ($past(state) == ST_CONV && state != ST_CONV) |-> $past(cnt) == CNT_W'(CONV_CYCLES - 1));
  assert_capture_R4: assert property (@(posedge clk) disable iff (rst)
    (state == ST_SLEEP && $past(state) == ST_CONV) |-> result == $past(sample_in));
  assert_wake_both_low_R5: assert property (@(posedge clk) disable iff (rst)
    (state == ST_DOUT && $past(state) == ST_SLEEP) |-> (!$past(cs_s) && !$past(sck_s)));
  assert_msb_first_R6: assert property (@(posedge clk) disable iff (rst)
    (state == ST_DOUT && $past(state) == ST_SLEEP && sdo_oe) |-> sdo == result[DATA_W-1]);
  assert_shift_step_R7: assert property (@(posedge clk) disable iff (rst)
    (state == ST_DOUT && $past(state) == ST_DOUT && $past(sck_fall) && !$past(cs_rise))
      |-> idx == IDX_W'($past(idx) - 1'b1));
  assert_last_edge_R8: assert property (@(posedge clk) disable iff (rst)
    ($past(state) == ST_DOUT && $past(sck_fall) && $past(idx) == '0) |-> state == ST_CONV);
  assert_cs_abort_R9: assert property (@(posedge clk) disable iff (rst)
    ($past(state) == ST_DOUT && $past(cs_rise)) |-> state == ST_CONV);
  assert_hold_R10: assert property (@(posedge clk) disable iff (rst)
    (state == ST_SLEEP && $past(state) == ST_SLEEP) |-> $stable(result));
  assert_lowpwr_sleep_R11: assert property (@(posedge clk) disable iff (rst)
    low_power |-> state == ST_SLEEP);
  assert_quiet_off_R12: assert property (@(posedge clk) disable iff (rst)
    !sdo_oe |-> !sdo);
endmodule

bind adc_serial_seq adc_serial_seq_chk #(
  .DATA_W(DATA_W), .CONV_CYCLES(CONV_CYCLES), .POR_CYCLES(POR_CYCLES)
) u_chk (
  .clk(clk), .rst(rst), .state(state), .cnt(cnt), .idx(idx), .result(result),
  .sample_in(sample_in), .cs_s(cs_s), .sck_s(sck_s), .cs_rise(cs_rise),
  .sck_fall(sck_fall), .sdo(sdo), .sdo_oe(sdo_oe), .low_power(low_power)
);

// File: tb/test_adc_serial_seq.sv
module test_adc_serial_seq;
  localparam int W    = 16;
  localparam int CONV = 40;
  localparam int POR  = 20;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cs_n = 1'b1;
  logic sck = 1'b1;
  logic [W-1:0] sample_in = '0;
  logic sdo, sdo_oe, low_power;

  int tests = 0;
  int fails = 0;
  bit done = 1'b0;
  logic [W-1:0] cur;

  always #10 clk = ~clk;

  adc_serial_seq #(.DATA_W(W), .CONV_CYCLES(CONV), .POR_CYCLES(POR)) i_adc_serial_seq (
    .clk(clk), .rst(rst), .cs_n(cs_n), .sck(sck), .sample_in(sample_in),
    .sdo(sdo), .sdo_oe(sdo_oe), .low_power(low_power)
  );

  function automatic int conv_latency();
    return CONV + 3;
  endfunction

  function automatic logic exp_bit(logic [W-1:0] v, int pos);
    return v[pos];
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  // mode 0: plain, 1: raise cs_n at cycle 6, 2: pin activity during conversion
  task automatic measure(int exp, int mode, string req);
    int n = 0;
    while (!low_power && n < 1000) begin
      @(posedge clk);
      n++;
      @(negedge clk);
      if (mode == 1 && n == 6) cs_n = 1'b1;
      if (mode == 2) begin
        if (n == 5) begin cs_n = 1'b0; sck = 1'b0; end
        if (n == 9) check(sdo == 1'b0, "R12 sdo idle in convert", sdo, 0);
        if (n == 12) sck = 1'b1;
        if (n == 15) sck = 1'b0;
        if (n == 18) begin cs_n = 1'b1; sck = 1'b1; end
      end
    end
    check(n == exp, req, n, exp);
  endtask

  task automatic readout(int k, logic [W-1:0] newv, int mode);
    cs_n = 1'b0;
    tick(5);
    check(low_power == 1'b0, "R11 low_power off with cs low", low_power, 0);
    check(sdo_oe == 1'b1, "R12 sdo_oe on", sdo_oe, 1);
    sck = 1'b0;
    tick(5);
    for (int i = 0; i < k; i++) begin
      check(sdo == exp_bit(cur, W - 1 - i), (i == 0) ? "R6 msb" : "R7 shift bit",
            sdo, exp_bit(cur, W - 1 - i));
      sck = 1'b1;
      tick(4);
      sck = 1'b0;
      if (i != W - 1) tick(4);
    end
    sample_in = newv;
    if (k == W) begin
      measure(conv_latency(), 1, "R8 conversion after 16th fall");
    end else begin
      cs_n = 1'b1;
      #1;
      check(sdo_oe == 1'b0 && sdo == 1'b0, "R12 off after cs high", {sdo_oe, sdo}, 0);
      measure(conv_latency(), mode, (mode == 2) ? "R3 no abort in convert" : "R9 cs abort");
    end
    cur = newv;
  endtask

  initial begin
    void'($urandom(32'd4711));
    tick(5);
    check(low_power == 1'b0, "R2 reset low_power", low_power, 0);
    check(sdo_oe == 1'b0 && sdo == 1'b0, "R2 reset outputs", {sdo_oe, sdo}, 0);
    cs_n = 1'b0;
    tick(2);
    check(sdo_oe == 1'b1 && sdo == 1'b0, "R12 enable follows cs", {sdo_oe, sdo}, 2);
    cs_n = 1'b1;
    cur = 16'hA5C3;
    sample_in = cur;
    rst = 1'b0;
    measure(POR + CONV, 0, "R2 R3 power-on then convert");

    sck = 1'b0;
    tick(6);
    check(low_power == 1'b1, "R5 sck low alone keeps sleep", low_power, 1);
    sck = 1'b1;
    tick(3);

    readout(W, 16'h3C5A, 0);
    readout(5, 16'h8001, 2);
    readout(0, 16'h7FFE, 0);

    for (int it = 0; it < 40; it++) begin
      int k = $urandom_range(0, W);
      int hold = $urandom_range(0, 40);
      logic [W-1:0] nv = W'($urandom);
      sample_in = W'($urandom);
      tick(hold);
      check(low_power == 1'b1, "R11 low_power in sleep", low_power, 1);
      readout(k, nv, (k == W) ? 1 : 0);
    end
    readout(W, 16'h0000, 0);
    readout(W, 16'hFFFF, 0);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule